// File: doc/BRIEF.md
# Multi-Size Shift and Rotate Unit

This execution unit shifts or rotates the low 8, 16 or 32 bits of a 32-bit register operand by one or two positions and reports the new condition flags. A CPU datapath places a register value on its input together with a size code, an operation code, an amount select and the current carry flag. One clock edge later the unit presents the full 32-bit word that should be written back to the same register, together with the carry, overflow, negative and zero flags.

Eight operations are available: arithmetic and logical shifts in both directions, plain rotates in both directions, and rotates in both directions through the carry flag. The through-carry rotates treat the carry as one extra bit beyond the top of the selected field, so each step moves one bit through it. Bits of the register above the selected field are returned untouched. The datapath is combinational, and one output register stage holds the result.

Top module: `bitmove_unit`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high at a rising edge, the result and all four flags are 0 after that edge.
- R2: The inputs are sampled at each rising edge, and the result and flags for them appear after that same edge and hold until the next edge. The amount is 1 position when `amt_two`=0 and 2 positions when `amt_two`=1.
- R3: Shift codes are `op_sel`=0 for arithmetic left, 1 for arithmetic right, 2 for logical left and 3 for logical right. Both left shifts fill with zeros. A logical right shift fills with zeros. An arithmetic right shift fills with the field's top bit. C is the last bit shifted out of the field.
- R4: Code 4 rotates left and code 5 rotates right within the field. The bits leaving one end enter at the other end, and C is the last bit that wrapped.
- R5: Code 6 rotates left and code 7 rotates right through the carry. The field and `carry_in` form a ring one bit wider than the field, with the carry above the field's top bit, and C is the new carry bit of that ring.
- R6: For code 0, V is 1 when the field's top-bit values seen during the shift are not all equal. These are the bits at positions W-1 and W-2, and also W-3 for a 2-position shift. For every other code, V is 0.
- R7: `size_sel`=0 selects an 8-bit field, 1 selects a 16-bit field, and 2 or 3 select the full 32 bits. Result bits above the field equal the operand bits.
- R8: N is the top bit of the result field. Z is 1 exactly when every bit of the result field is 0, whatever the bits above the field hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd | input | 32 | Register operand |
| size_sel | input | 2 | Field size: 0 byte, 1 word, 2/3 longword |
| op_sel | input | 3 | Operation code 0..7 |
| amt_two | input | 1 | 0 selects one position, 1 selects two positions |
| carry_in | input | 1 | Current carry flag |
| res_q | output | 32 | Registered write-back value |
| c_q | output | 1 | Registered carry flag |
| v_q | output | 1 | Registered overflow flag |
| n_q | output | 1 | Registered negative flag |
| z_q | output | 1 | Registered zero flag |

## Verification
Apart from the output register, the unit holds no state, so any fault shows up one edge after the input that exposes it. A wrong lane selection or field mask shows as corrupted upper bits, or as N and Z taken from the wrong bit position. A broken second step of a 2-position operation shows as a wrong carry or a lost carry bit in the through-carry ring. Such faults are visible only for the sizes and amounts that exercise them, so the bench applies every code at every size and amount with both carry values.

// File: rtl/bitmove_pkg.sv
package bitmove_pkg;

    localparam int unsigned BASE_W    = 8;
    localparam int unsigned NUM_LANES = 3;
    localparam int unsigned DATA_W    = BASE_W << (NUM_LANES - 1);
    localparam int unsigned IDX_W     = $clog2(NUM_LANES);

    typedef enum logic [2:0] {
        OP_ASHL = 3'd0,
        OP_ASHR = 3'd1,
        OP_LSHL = 3'd2,
        OP_LSHR = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_RCL  = 3'd6,
        OP_RCR  = 3'd7
    } bm_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } bm_size_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } bm_flags_t;

    function automatic int unsigned lane_width(int unsigned idx);
        return BASE_W << idx;
    endfunction

    function automatic logic [IDX_W-1:0] lane_index(bm_size_e sz);
        case (sz)
            SZ_BYTE: return IDX_W'(0);
            SZ_WORD: return IDX_W'(1);
            default: return IDX_W'(NUM_LANES - 1);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < int'(DATA_W); b++) begin
            if (b < int'(lane_width(32'(idx)))) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bm_lane.sv
module bm_lane
    import bitmove_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] fld,
    input  bm_op_e       op,
    input  logic         amt_two,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         vout
);

    typedef struct packed {
        logic         v;
        logic         c;
        logic [W-1:0] d;
    } step_t;

    function automatic step_t one_step(logic [W-1:0] d, logic c, bm_op_e o);
        step_t s;
        s.v = 1'b0;
        s.c = 1'b0;
        s.d = d;
        case (o)
            OP_ASHL, OP_LSHL: begin
                s.d = {d[W-2:0], 1'b0};
                s.c = d[W-1];
                s.v = (o == OP_ASHL) && (d[W-1] != d[W-2]);
            end
            OP_ASHR: begin
                s.d = {d[W-1], d[W-1:1]};
                s.c = d[0];
            end
            OP_LSHR: begin
                s.d = {1'b0, d[W-1:1]};
                s.c = d[0];
            end
            OP_ROL: begin
                s.d = {d[W-2:0], d[W-1]};
                s.c = d[W-1];
            end
            OP_ROR: begin
                s.d = {d[0], d[W-1:1]};
                s.c = d[0];
            end
            OP_RCL: begin
                s.d = {d[W-2:0], c};
                s.c = d[W-1];
            end
            default: begin
                s.d = {c, d[W-1:1]};
                s.c = d[0];
            end
        endcase
        return s;
    endfunction

    step_t first, second;

    always_comb begin
        first  = one_step(fld, cin, op);
        second = one_step(first.d, first.c, op);
        if (amt_two) begin
            res  = second.d;
            cout = second.c;
            vout = first.v | second.v;
        end else begin
            res  = first.d;
            cout = first.c;
            vout = first.v;
        end
    end

endmodule

// File: rtl/bm_flag_gen.sv
module bm_flag_gen
    import bitmove_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic [DW-1:0]    fld_res,
    input  logic [IDX_W-1:0] lane_sel,
    output logic             neg,
    output logic             zero
);

    always_comb begin
        neg = 1'b0;
        for (int i = 0; i < int'(NUM_LANES); i++) begin
            if (lane_sel == IDX_W'(i)) neg = fld_res[lane_width(32'(i)) - 1];
        end
        zero = (fld_res == '0);
    end

endmodule

// File: rtl/bitmove_unit.sv
module bitmove_unit
    import bitmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] opnd,
    input  logic [1:0]        size_sel,
    input  logic [2:0]        op_sel,
    input  logic              amt_two,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_q,
    output logic              c_q,
    output logic              v_q,
    output logic              n_q,
    output logic              z_q
);

    bm_op_e            op;
    logic [IDX_W-1:0]  sel;
    logic [DATA_W-1:0] lane_res [NUM_LANES];
    logic              lane_c   [NUM_LANES];
    logic              lane_v   [NUM_LANES];
    logic [DATA_W-1:0] fld_res;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] merged;
    logic              sel_c, sel_v, f_n, f_z;
    bm_flags_t         flags_q;

    assign op  = bm_op_e'(op_sel);
    assign sel = lane_index(bm_size_e'(size_sel));

    for (genvar i = 0; i < int'(NUM_LANES); i++) begin : g_lane
        localparam int unsigned LW = lane_width(i);
        logic [LW-1:0] r;
        bm_lane #(.W(LW)) u_lane (
            .fld     (opnd[LW-1:0]),
            .op      (op),
            .amt_two (amt_two),
            .cin     (carry_in),
            .res     (r),
            .cout    (lane_c[i]),
            .vout    (lane_v[i])
        );
        assign lane_res[i] = DATA_W'(r);
    end

    always_comb begin
        fld_res = '0;
        sel_c   = 1'b0;
        sel_v   = 1'b0;
        for (int i = 0; i < int'(NUM_LANES); i++) begin
            if (sel == IDX_W'(i)) begin
                fld_res = lane_res[i];
                sel_c   = lane_c[i];
                sel_v   = lane_v[i];
            end
        end
        keep_mask = ~lane_mask(sel);
        merged    = (opnd & keep_mask) | fld_res;
    end

    bm_flag_gen #(.DW(DATA_W)) u_flags (
        .fld_res  (fld_res),
        .lane_sel (sel),
        .neg      (f_n),
        .zero     (f_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= merged;
            flags_q <= '{c: sel_c, v: sel_v, n: f_n, z: f_z};
        end
    end

    assign c_q = flags_q.c;
    assign v_q = flags_q.v;
    assign n_q = flags_q.n;
    assign z_q = flags_q.z;

endmodule

// File: rtl/bitmove_checker.sv
module bitmove_checker
    import bitmove_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] opnd,
    input logic [1:0]        size_sel,
    input logic [2:0]        op_sel,
    input logic              carry_in,
    input logic [DATA_W-1:0] res_q,
    input logic              c_q,
    input logic              v_q,
    input logic              n_q,
    input logic              z_q
);

    logic              live;
    logic [DATA_W-1:0] p_opnd;
    logic [1:0]        p_size;
    logic [2:0]        p_op;
    logic              p_cin;
    logic [DATA_W-1:0] p_mask;

    always_ff @(posedge clk) begin
        live   <= !rst;
        p_opnd <= opnd;
        p_size <= size_sel;
        p_op   <= op_sel;
        p_cin  <= carry_in;
    end

    assign p_mask = lane_mask(lane_index(bm_size_e'(p_size)));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !c_q && !v_q && !n_q && !z_q));

    assert_upper_keep_R7: assert property (@(posedge clk) disable iff (rst)
        live |-> ((res_q & ~p_mask) == (p_opnd & ~p_mask)));

    assert_lsr_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (live && p_op == 3'(OP_LSHR)) |-> !n_q);

    assert_rot_ones_R4: assert property (@(posedge clk) disable iff (rst)
        (live && (p_op == 3'(OP_ROL) || p_op == 3'(OP_ROR)))
        |-> ($countones(res_q & p_mask) == $countones(p_opnd & p_mask)));

    assert_ring_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (live && (p_op == 3'(OP_RCL) || p_op == 3'(OP_RCR)))
        |-> (($countones(res_q & p_mask) + int'(c_q))
             == ($countones(p_opnd & p_mask) + int'(p_cin))));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (live && p_op != 3'(OP_ASHL)) |-> !v_q);

    assert_zero_field_R8: assert property (@(posedge clk) disable iff (rst)
        (live && z_q) |-> ((res_q & p_mask) == '0));

endmodule

bind bitmove_unit bitmove_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .opnd     (opnd),
    .size_sel (size_sel),
    .op_sel   (op_sel),
    .carry_in (carry_in),
    .res_q    (res_q),
    .c_q      (c_q),
    .v_q      (v_q),
    .n_q      (n_q),
    .z_q      (z_q)
);

// File: tb/bitmove_unit_bench.sv
`timescale 1ns/1ps
module bitmove_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd = 32'h0;
    logic [1:0]  size_sel = 2'd0;
    logic [2:0]  op_sel = 3'd0;
    logic        amt_two = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] res_q;
    logic        c_q, v_q, n_q, z_q;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bitmove_unit u_bitmove_unit (
        .clk(clk), .rst(rst), .opnd(opnd), .size_sel(size_sel),
        .op_sel(op_sel), .amt_two(amt_two), .carry_in(carry_in),
        .res_q(res_q), .c_q(c_q), .v_q(v_q), .n_q(n_q), .z_q(z_q)
    );

    function automatic logic [35:0] outs();
        return {v_q, n_q, z_q, c_q, res_q};
    endfunction

    // Expected {v,n,z,c,result} from the requirements.
    function automatic logic [35:0] model(int op, int sz, bit two, bit cin, logic [31:0] x);
        int w, k;
        logic [63:0] m, m1, f, r, e, e2, t;
        bit c, v;
        w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        k  = two ? 2 : 1;
        m  = (64'd1 << w) - 64'd1;
        m1 = (64'd1 << (w + 1)) - 64'd1;
        f  = {32'h0, x} & m;
        v  = 1'b0;
        r  = '0;
        c  = 1'b0;
        case (op)
            0, 2: begin r = (f << k) & m; c = f[w-k]; end
            1: begin
                r = f >> k;
                if (f[w-1]) r = r | (m & ~(m >> k));
                c = f[k-1];
            end
            3: begin r = f >> k; c = f[k-1]; end
            4: begin r = ((f << k) | (f >> (w - k))) & m; c = f[w-k]; end
            5: begin r = ((f >> k) | (f << (w - k))) & m; c = f[k-1]; end
            default: begin
                e = f | (64'(cin) << w);
                if (op == 6) e2 = ((e << k) | (e >> (w + 1 - k))) & m1;
                else         e2 = ((e >> k) | (e << (w + 1 - k))) & m1;
                r = e2 & m;
                c = e2[w];
            end
        endcase
        if (op == 0) begin
            t = (f >> (w - 1 - k)) & ((64'd1 << (k + 1)) - 64'd1);
            v = (t != 0) && (t != ((64'd1 << (k + 1)) - 64'd1));
        end
        return {v, r[w-1], (r == 0), c, (x & ~m[31:0]) | r[31:0]};
    endfunction

    task automatic chk(string tag, logic [35:0] got, logic [35:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(int op, int sz, bit two, bit cin, logic [31:0] x);
        @(negedge clk);
        op_sel = 3'(op); size_sel = 2'(sz); amt_two = two; carry_in = cin; opnd = x;
        @(negedge clk);
    endtask

    task automatic directed(string tag, int op, int sz, bit two, bit cin,
                            logic [31:0] x, logic [35:0] exp);
        apply(op, sz, two, cin, x);
        chk(tag, outs(), exp);
        chk({tag, " model"}, outs(), model(op, sz, two, cin, x));
    endtask

    function automatic string op_tag(int op, int sz);
        if (sz == 3) return "R7";
        case (op)
            0: return "R6";
            1, 2, 3: return "R3";
            4, 5: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        opnd = 32'hFFFF_FFFF; op_sel = 3'd4; size_sel = 2'd2; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset state", outs(), 36'h0);
        rst = 1'b0;
    endtask

    task automatic t_latency();
        apply(3, 2, 1'b0, 1'b0, 32'h0000_0010);
        chk("R2 first result", outs(), 36'h0_0000_0008);
        @(negedge clk);
        opnd = 32'h0000_0100;
        #1;
        chk("R2 hold before edge", outs(), 36'h0_0000_0008);
        @(negedge clk);
        chk("R2 after edge", outs(), 36'h0_0000_0080);
    endtask

    task automatic t_shifts();
        directed("R3 asr byte sign fill", 1, 0, 1'b0, 1'b0, 32'h0000_0080, 36'h4_0000_00C0);
        directed("R3 lsr long two", 3, 2, 1'b1, 1'b0, 32'h8000_0003, 36'h1_2000_0000);
        directed("R3 lsl byte two", 2, 0, 1'b1, 1'b0, 32'hDEAD_BEFF, 36'h5_DEAD_BEFC);
        directed("R3 asr size3 two", 1, 3, 1'b1, 1'b0, 32'h8000_0000, 36'h4_E000_0000);
    endtask

    task automatic t_rotates();
        directed("R4 ror word two", 5, 1, 1'b1, 1'b0, 32'h0000_0001, 36'h0_0000_4000);
        directed("R4 rol long one", 4, 2, 1'b0, 1'b0, 32'h8000_0000, 36'h1_0000_0001);
    endtask

    task automatic t_ring();
        directed("R5 rcl byte two", 6, 0, 1'b1, 1'b0, 32'h0000_0081, 36'h0_0000_0005);
        directed("R5 rcr word two", 7, 1, 1'b1, 1'b1, 32'h0000_0002, 36'h1_0000_4000);
    endtask

    task automatic t_overflow();
        directed("R6 asl byte one", 0, 0, 1'b0, 1'b0, 32'h0000_0040, 36'hC_0000_0080);
        directed("R6 asl word two", 0, 1, 1'b1, 1'b0, 32'h0000_2000, 36'hC_0000_8000);
        directed("R6 lsl no overflow", 2, 1, 1'b0, 1'b0, 32'h0000_4000, 36'h4_0000_8000);
    endtask

    task automatic t_flags();
        directed("R8 zero with upper bits", 3, 0, 1'b0, 1'b0, 32'h1234_5601, 36'h3_1234_5600);
    endtask

    task automatic t_sweep();
        logic [31:0] pats [8];
        pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678,
                 32'hA5C3_9E81, 32'h4000_4040, 32'h7F7F_7F7F, 32'h0000_00C0};
        for (int p = 0; p < 8; p++)
            for (int op = 0; op < 8; op++)
                for (int sz = 0; sz < 4; sz++)
                    for (int tw = 0; tw < 2; tw++)
                        for (int ci = 0; ci < 2; ci++) begin
                            apply(op, sz, tw[0], ci[0], pats[p]);
                            chk($sformatf("%s sweep op%0d sz%0d two%0d cin%0d pat%h",
                                          op_tag(op, sz), op, sz, tw, ci, pats[p]),
                                outs(), model(op, sz, tw[0], ci[0], pats[p]));
                        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_shifts();
        t_rotates();
        t_ring();
        t_overflow();
        t_flags();
        t_sweep();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

endmodule